// File: doc/BRIEF.md
# Charge-Path Protection Timing Controller

This block is the digital timing core behind the charge switch of a two-cell battery protector. It receives single-bit comparator results: an over-charge flag for each cell, a flag for each cell showing that it sits below the over-charge release level, an excess-charge-current flag, charger-present, load-present and a request to shorten delays. It also receives a periodic timebase tick. Every comparator input passes through a two-flop synchronizer before it is used.

Each fault must be seen without a break for its own number of ticks before it is latched. When a fault is latched, the charge enable goes low. Each latched fault also has its own release condition, and that condition must hold without a break for its own number of ticks before the fault clears. Over-charge has two ways to release. The first is both cells below the release level while the charger stays connected. The second is both cells below the detect level with the charger removed and a load present. Excess charge current releases only through charger removal with a load present. While the enable is high, a delay-shorten request divides the over-charge detect interval by a parameter ratio.

Top module: `chg_guard`

## Requirements
- R1: While reset is asserted and after it is released with all inputs low, `chg_en_o` is 1 and `status_o` is 2'b00.
- R2: If either cell's over-charge flag stays high for OVC_DET_TICKS ticks, the over-charge fault latches on that last tick and `status_o[0]` goes to 1. After one tick fewer, the fault is still clear.
- R3: If the over-charge flag drops before the detect count completes, nothing is latched. The next assertion counts again from zero.
- R4: A latched over-charge releases after OVC_REL_TICKS ticks in which both below-release flags are 1 and the charger is present.
- R5: A latched over-charge also releases after OVC_REL_TICKS ticks in which both over-charge flags are 0, the charger is absent and a load is present.
- R6: If a release condition lapses before its count completes, the fault stays latched. The release count then restarts from zero.
- R7: If the excess-charge-current flag stays high for XCC_DET_TICKS ticks, the excess-charge fault latches (`status_o[1]` = 1). After one tick fewer, it is still clear.
- R8: A latched excess-charge fault releases only after XCC_REL_TICKS ticks with the charger absent and a load present. While the charger is present, it never releases.
- R9: While `chg_en_o` is 1 and delay-shorten is requested, the over-charge detect count is OVC_DET_TICKS/DS_RATIO ticks (at least 1). While `chg_en_o` is 0, the request has no effect.
- R10: `status_o` encodes bit 0 = over-charge latched and bit 1 = excess-charge latched (00 none, 01 over-charge, 10 excess-charge, 11 both). `chg_en_o` is 1 exactly when `status_o` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one clock wide, synchronous |
| ovc_a_i | input | 1 | Cell A at or above over-charge threshold |
| ovc_b_i | input | 1 | Cell B at or above over-charge threshold |
| blw_a_i | input | 1 | Cell A below over-charge release level |
| blw_b_i | input | 1 | Cell B below over-charge release level |
| xcc_i | input | 1 | Excess charge current sensed |
| chgr_i | input | 1 | Charger present |
| load_i | input | 1 | Load present |
| dshort_i | input | 1 | Delay-shorten request |
| chg_en_o | output | 1 | Charge switch enable, high = charging allowed |
| status_o | output | 2 | Latched fault code |

## Verification
Over-charge detection is driven once from each cell's flag and stopped one tick short of the limit, which shows that a single cell can trip it and that the count is exact. A glitch followed by a full-length hold separates a count that restarts from one that accumulates. The two release routes are tried separately, and a release that lapses part way shows whether the release count restarts. Excess-current release is tried with the charger still attached and then removed. Delay-shorten is tried once with the enable high and once with it low, so that a ratio applied without regard to the enable is caught. The stacked-fault case exercises the 11 code and the release of one fault while the other stays latched.

// File: rtl/chg_guard_pkg.sv
`timescale 1ns/1ps
package chg_guard_pkg;

  typedef enum logic [1:0] {
    ST_NONE = 2'b00,
    ST_OVC  = 2'b01,
    ST_XCC  = 2'b10,
    ST_BOTH = 2'b11
  } chg_stat_e;

  localparam int NUM_IN  = 8;
  localparam int IX_OVCA = 0;
  localparam int IX_OVCB = 1;
  localparam int IX_BLWA = 2;
  localparam int IX_BLWB = 3;
  localparam int IX_XCC  = 4;
  localparam int IX_CHGR = 5;
  localparam int IX_LOAD = 6;
  localparam int IX_DSH  = 7;

  localparam int NUM_TMR   = 4;
  localparam int T_OVC_DET = 0;
  localparam int T_OVC_REL = 1;
  localparam int T_XCC_DET = 2;
  localparam int T_XCC_REL = 3;

endpackage

// File: rtl/chg_rst_sync.sv
`timescale 1ns/1ps
module chg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/chg_sync.sv
`timescale 1ns/1ps
module chg_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/chg_persist.sv
`timescale 1ns/1ps
module chg_persist #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;
  logic          cnt_en;
  logic          reach;

  assign cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign reach   = (cnt_inc >= {1'b0, limit_i});
  assign fire_o  = arm_i & tick_i & reach;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!arm_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick_i) begin
      cnt_en = 1'b1;
      cnt_d  = reach ? '0 : cnt_inc[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/chg_guard.sv
`timescale 1ns/1ps
module chg_guard
  import chg_guard_pkg::*;
#(
  parameter int OVC_DET_TICKS = 100000,
  parameter int OVC_REL_TICKS = 1600,
  parameter int XCC_DET_TICKS = 800,
  parameter int XCC_REL_TICKS = 120,
  parameter int DS_RATIO      = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ovc_a_i,
  input  logic       ovc_b_i,
  input  logic       blw_a_i,
  input  logic       blw_b_i,
  input  logic       xcc_i,
  input  logic       chgr_i,
  input  logic       load_i,
  input  logic       dshort_i,
  output logic       chg_en_o,
  output logic [1:0] status_o
);

  localparam int MAX_A    = (OVC_DET_TICKS > OVC_REL_TICKS) ? OVC_DET_TICKS : OVC_REL_TICKS;
  localparam int MAX_B    = (XCC_DET_TICKS > XCC_REL_TICKS) ? XCC_DET_TICKS : XCC_REL_TICKS;
  localparam int MAX_TCK  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(MAX_TCK + 1);
  localparam int OVC_FAST_RAW = OVC_DET_TICKS / DS_RATIO;
  localparam int OVC_FAST = (OVC_FAST_RAW < 1) ? 1 : OVC_FAST_RAW;

  logic rst_i_n;
  logic [NUM_IN-1:0] raw_in, syn;

  chg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    raw_in          = '0;
    raw_in[IX_OVCA] = ovc_a_i;
    raw_in[IX_OVCB] = ovc_b_i;
    raw_in[IX_BLWA] = blw_a_i;
    raw_in[IX_BLWB] = blw_b_i;
    raw_in[IX_XCC]  = xcc_i;
    raw_in[IX_CHGR] = chgr_i;
    raw_in[IX_LOAD] = load_i;
    raw_in[IX_DSH]  = dshort_i;
  end

  chg_sync #(.W(NUM_IN)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d_i   (raw_in),
    .q_o   (syn)
  );

  logic ovc_flt_q, ovc_flt_d;
  logic xcc_flt_q, xcc_flt_d;
  logic en_now;
  logic ovc_any, rel_lvl, rel_unplug, unplug_load;

  assign en_now      = ~(ovc_flt_q | xcc_flt_q);
  assign ovc_any     = syn[IX_OVCA] | syn[IX_OVCB];
  assign unplug_load = ~syn[IX_CHGR] & syn[IX_LOAD];
  assign rel_lvl     = syn[IX_BLWA] & syn[IX_BLWB] & syn[IX_CHGR];
  assign rel_unplug  = ~ovc_any & unplug_load;

  logic [NUM_TMR-1:0] arm, fire;
  logic [CW-1:0]      lim [NUM_TMR];

  always_comb begin
    arm[T_OVC_DET] = ovc_any & ~ovc_flt_q;
    arm[T_OVC_REL] = ovc_flt_q & (rel_lvl | rel_unplug);
    arm[T_XCC_DET] = syn[IX_XCC] & ~xcc_flt_q;
    arm[T_XCC_REL] = xcc_flt_q & unplug_load;
    lim[T_OVC_DET] = (syn[IX_DSH] & en_now) ? CW'(OVC_FAST) : CW'(OVC_DET_TICKS);
    lim[T_OVC_REL] = CW'(OVC_REL_TICKS);
    lim[T_XCC_DET] = CW'(XCC_DET_TICKS);
    lim[T_XCC_REL] = CW'(XCC_REL_TICKS);
  end

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    chg_persist #(.CW(CW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .arm_i   (arm[gi]),
      .tick_i  (tick_i),
      .limit_i (lim[gi]),
      .fire_o  (fire[gi])
    );
  end

  always_comb begin
    ovc_flt_d = ovc_flt_q ? ~fire[T_OVC_REL] : fire[T_OVC_DET];
    xcc_flt_d = xcc_flt_q ? ~fire[T_XCC_REL] : fire[T_XCC_DET];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ovc_flt_q <= 1'b0;
      xcc_flt_q <= 1'b0;
    end else begin
      ovc_flt_q <= ovc_flt_d;
      xcc_flt_q <= xcc_flt_d;
    end
  end

  chg_stat_e stat;
  assign stat     = chg_stat_e'({xcc_flt_q, ovc_flt_q});
  assign status_o = stat;
  assign chg_en_o = en_now;

endmodule

// File: rtl/chg_guard_chk.sv
`timescale 1ns/1ps
module chg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       ovc_a_i,
  input logic       ovc_b_i,
  input logic       chgr_i,
  input logic [1:0] status_o
);
  // R2: over-charge latches only on a tick
  a_r2_ovc_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(tick_i));

  // R2: over-charge latches only when a cell flag was high through the synchronizer
  a_r2_ovc_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> ($past(ovc_a_i, 3) | $past(ovc_b_i, 3)));

  // R6: over-charge releases only on a tick
  a_r6_rel_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> $past(tick_i));

  // R7: excess-charge latches only on a tick
  a_r7_xcc_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(tick_i));

  // R8: excess-charge never releases with the charger present
  a_r8_xcc_rel_unplugged: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[1]) |-> !$past(chgr_i, 3));
endmodule

bind chg_guard chg_guard_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_i   (tick_i),
  .ovc_a_i  (ovc_a_i),
  .ovc_b_i  (ovc_b_i),
  .chgr_i   (chgr_i),
  .status_o (status_o)
);

// File: tb/chg_guard_tb_top.sv
`timescale 1ns/1ps
module chg_guard_tb_top;
  // Compressed timebase: one tick every four clocks, small interval counts.
  localparam int OD = 120;
  localparam int OR = 16;
  localparam int XD = 8;
  localparam int XR = 4;
  localparam int DS = 60;
  localparam int OF = OD / DS;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_i, ovc_a_i, ovc_b_i, blw_a_i, blw_b_i, xcc_i, chgr_i, load_i, dshort_i;
  logic chg_en_o;
  logic [1:0] status_o;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  chg_guard #(
    .OVC_DET_TICKS(OD), .OVC_REL_TICKS(OR),
    .XCC_DET_TICKS(XD), .XCC_REL_TICKS(XR), .DS_RATIO(DS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .ovc_a_i(ovc_a_i), .ovc_b_i(ovc_b_i), .blw_a_i(blw_a_i), .blw_b_i(blw_b_i),
    .xcc_i(xcc_i), .chgr_i(chgr_i), .load_i(load_i), .dshort_i(dshort_i),
    .chg_en_o(chg_en_o), .status_o(status_o)
  );

  task automatic expect_st(input string tag, input logic [1:0] st);
    logic [2:0] act, exp;
    act = {chg_en_o, status_o};
    exp = {(st == 2'b00), st};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual en/status=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    {tick_i, ovc_a_i, ovc_b_i, blw_a_i, blw_b_i, xcc_i, chgr_i, load_i, dshort_i} = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_st("R1 in reset", 2'b00);
    rst_n = 1'b1;
    settle();
    expect_st("R1 after reset", 2'b00);
  endtask

  task automatic t_ovc_level_release();
    chgr_i = 1'b1; ovc_a_i = 1'b1; settle();
    ticks(OD - 1);
    expect_st("R2 one tick short", 2'b00);
    ticks(1);
    expect_st("R2 cell A detect", 2'b01);
    ovc_a_i = 1'b0; blw_a_i = 1'b1; blw_b_i = 1'b1; settle();
    ticks(10);
    blw_a_i = 1'b0; settle(); ticks(3);
    blw_a_i = 1'b1; settle();
    ticks(OR - 1);
    expect_st("R6 lapse restarts release", 2'b01);
    ticks(1);
    expect_st("R4 level release", 2'b00);
  endtask

  task automatic t_ovc_glitch_unplug();
    blw_a_i = 1'b0; blw_b_i = 1'b0;
    ovc_b_i = 1'b1; settle(); ticks(100);
    ovc_b_i = 1'b0; settle(); ticks(5);
    expect_st("R3 glitch no detect", 2'b00);
    ovc_b_i = 1'b1; settle();
    ticks(OD - 1);
    expect_st("R3 count restarted", 2'b00);
    ticks(1);
    expect_st("R2 cell B detect", 2'b01);
    ovc_b_i = 1'b0; chgr_i = 1'b0; load_i = 1'b1; settle();
    ticks(OR - 1);
    expect_st("R5 unplug hold", 2'b01);
    ticks(1);
    expect_st("R5 unplug release", 2'b00);
  endtask

  task automatic t_xcc();
    load_i = 1'b0; chgr_i = 1'b1; xcc_i = 1'b1; settle();
    ticks(XD - 1);
    expect_st("R7 one tick short", 2'b00);
    ticks(1);
    expect_st("R7 excess detect", 2'b10);
    xcc_i = 1'b0; load_i = 1'b1; settle();
    ticks(XR + 6);
    expect_st("R8 charger attached no release", 2'b10);
    chgr_i = 1'b0; settle();
    ticks(XR - 1);
    expect_st("R8 release hold", 2'b10);
    ticks(1);
    expect_st("R8 release", 2'b00);
  endtask

  task automatic t_dshort();
    load_i = 1'b0; chgr_i = 1'b1; dshort_i = 1'b1; ovc_a_i = 1'b1; settle();
    ticks(OF - 1);
    expect_st("R9 short one tick early", 2'b00);
    ticks(1);
    expect_st("R9 shortened detect", 2'b01);
    dshort_i = 1'b0; ovc_a_i = 1'b0; blw_a_i = 1'b1; blw_b_i = 1'b1; settle();
    ticks(OR);
    expect_st("R4 release after short", 2'b00);
    blw_a_i = 1'b0; blw_b_i = 1'b0;
    xcc_i = 1'b1; settle(); ticks(XD);
    expect_st("R10 excess code", 2'b10);
    xcc_i = 1'b0; dshort_i = 1'b1; ovc_a_i = 1'b1; settle();
    ticks(OF + 2);
    expect_st("R9 no shorten with enable low", 2'b10);
    ticks(OD - OF - 2);
    expect_st("R10 both faults", 2'b11);
    dshort_i = 1'b0; ovc_a_i = 1'b0; chgr_i = 1'b0; load_i = 1'b1; settle();
    ticks(XR);
    expect_st("R10 over-charge only left", 2'b01);
    ticks(OR - XR);
    expect_st("R10 all clear", 2'b00);
  endtask

  initial begin
    t_reset();
    t_ovc_level_release();
    t_ovc_glitch_unplug();
    t_xcc();
    t_dshort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule